// File: doc/BRIEF.md
# Function-Code Bus Space Decoder

This block sits next to a 68000-style processor bus inside an FPGA. For every bus cycle it forms the three-bit function code, which names the address space in use: user or supervisor, combined with program, data or CPU space. It then uses that code to steer the cycle to one of three targets: a ROM, a RAM or a hardware I/O window. Cycles from user mode that try to reach the I/O window are refused with a one-cycle fault pulse, which the system can turn into a bus error.

A boot overlay puts the ROM at the bottom of the address map after reset, so the processor can read its start-up vectors. Supervisor software removes the overlay by writing to a fixed control address inside the I/O window. After that, the RAM answers at the bottom of the map.

The function code and the selects are registered. They are captured on the clock edge that sees the address strobe rise. The function code then holds until the next strobe rise. The selects fall on the edge after the strobe falls.

Top module: `fc_space_decoder`

## Requirements
- R1: The top function-code bit `fc_o[2]` equals the supervisor input `sup_i` sampled at the start of each memory cycle.
- R2: An opcode fetch (`kind_i` = 0) gives `fc_o[1:0]` = 2'b10 (program space).
- R3: A PC-relative operand read (`kind_i` = 1) gives `fc_o[1:0]` = 2'b10, the same as a fetch.
- R4: An ordinary operand read or write (`kind_i` = 2) gives `fc_o[1:0]` = 2'b01 (data space).
- R5: An interrupt acknowledge (`kind_i` = 3) gives `fc_o` = 3'b111 and asserts no chip select and no fault.
- R6: Outputs update on the clock edge where `as_i` is first seen high. While the strobe stays high, `fc_o` and the selects ignore changes on the other inputs. After the strobe falls, the selects clear on the next edge and `fc_o` keeps its value.
- R7: A user-mode cycle to the I/O window (0xE00000 to 0xE0FFFF) raises `prot_fault_o` for exactly one cycle and does not assert `io_cs_o`. The same cycle in supervisor mode asserts `io_cs_o` and raises no fault.
- R8: During and after reset, `fc_o` is 3'b110, all selects and the fault are low, and the overlay is active. While the overlay is active, addresses 0x000000 to 0x00FFFF select the ROM.
- R9: A supervisor operand write to the control address 0xE0FFFE removes the overlay, and the low window then selects RAM. The same write made in user mode faults and leaves the overlay in place.
- R10: Outside the overlay, the ROM answers at 0xF00000 to 0xF0FFFF and the RAM answers at 0x000000 to 0x0FFFFF. Any other address selects nothing. At most one select is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_i | input | 1 | Supervisor bit from the status register |
| kind_i | input | 2 | Access kind: 0 fetch, 1 PC-relative read, 2 operand read/write, 3 interrupt acknowledge |
| wr_i | input | 1 | 1 for a write cycle |
| as_i | input | 1 | Address strobe, active high |
| addr_i | input | ADDR_W (24) | Byte address of the cycle |
| fc_o | output | 3 | Registered function code |
| rom_cs_o | output | 1 | ROM select |
| ram_cs_o | output | 1 | RAM select |
| io_cs_o | output | 1 | I/O window select |
| prot_fault_o | output | 1 | One-cycle pulse for a refused user access |

## Verification
The hardest case to reach from the ports is the overlay state. It can only be seen indirectly, through which device answers at the bottom of the map. It changes only on one exact write.

Directed stimulus first makes a user-mode write to the control address, then reads address zero to show the ROM still answers. It then makes the supervisor write and reads zero again to show the RAM now answers. In the random phase, a small share of supervisor writes go to the control address, and the bench model follows the overlay state.

Every cycle also changes the mode, kind and address while the strobe is held high. This shows the registered code does not follow inputs in the middle of a cycle.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_PCREL = 2'd1,
        ACC_DATA  = 2'd2,
        ACC_IACK  = 2'd3
    } acc_kind_e;

    localparam logic [1:0] SPACE_DATA = 2'b01;
    localparam logic [1:0] SPACE_PROG = 2'b10;
    localparam logic [2:0] FC_CPU     = 3'b111;
    localparam logic [2:0] FC_RESET   = 3'b110;

    typedef struct packed {
        logic [2:0] fc;
        logic       rom_cs;
        logic       ram_cs;
        logic       io_cs;
        logic       fault;
        logic       overlay;
        logic       as_prev;
    } fcd_state_t;

endpackage

// File: rtl/fcd_fc_encode.sv
module fcd_fc_encode
    import fcd_pkg::*;
(
    input  logic       sup_i,
    input  logic [1:0] kind_i,
    output logic [2:0] fc_o
);
    always_comb begin
        unique case (acc_kind_e'(kind_i))
            ACC_FETCH: fc_o = {sup_i, SPACE_PROG};
            ACC_PCREL: fc_o = {sup_i, SPACE_PROG};
            ACC_DATA:  fc_o = {sup_i, SPACE_DATA};
            default:   fc_o = FC_CPU;
        endcase
    end
endmodule

// File: rtl/fcd_region_match.sv
module fcd_region_match #(
    parameter int              ADDR_W  = 24,
    parameter int              SPAN_AW = 16,
    parameter logic [ADDR_W-1:0] BASE  = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam logic [ADDR_W-1:0] BASE_TOP = BASE >> SPAN_AW;

    always_comb hit_o = ((addr_i >> SPAN_AW) == BASE_TOP);
endmodule

// File: rtl/fcd_region_decode.sv
module fcd_region_decode #(
    parameter int                ADDR_W   = 24,
    parameter int                ROM_AW   = 16,
    parameter int                RAM_AW   = 20,
    parameter int                IO_AW    = 16,
    parameter logic [ADDR_W-1:0] ROM_BASE = 24'hF00000,
    parameter logic [ADDR_W-1:0] RAM_BASE = 24'h000000,
    parameter logic [ADDR_W-1:0] IO_BASE  = 24'hE00000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        fc_i,
    input  logic              overlay_i,
    output logic              sel_rom_o,
    output logic              sel_ram_o,
    output logic              sel_io_o
);
    localparam int NREG = 4;   // rom, ram, io, boot window

    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_match
        localparam int                SPAN = (g == 0) ? ROM_AW :
                                             (g == 1) ? RAM_AW :
                                             (g == 2) ? IO_AW  : ROM_AW;
        localparam logic [ADDR_W-1:0] BASE = (g == 0) ? ROM_BASE :
                                             (g == 1) ? RAM_BASE :
                                             (g == 2) ? IO_BASE  : '0;
        fcd_region_match #(
            .ADDR_W (ADDR_W),
            .SPAN_AW(SPAN),
            .BASE   (BASE)
        ) u_match (
            .addr_i(addr_i),
            .hit_o (hit[g])
        );
    end

    logic cpu_space;
    logic boot_map;

    always_comb begin
        cpu_space = (fc_i == fcd_pkg::FC_CPU);
        boot_map  = overlay_i && hit[3];
        sel_rom_o = !cpu_space && (hit[0] || boot_map);
        sel_ram_o = !cpu_space && hit[1] && !boot_map;
        sel_io_o  = !cpu_space && hit[2];
    end
endmodule

// File: rtl/fc_space_decoder.sv
module fc_space_decoder
    import fcd_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                ROM_AW    = 16,
    parameter int                RAM_AW    = 20,
    parameter int                IO_AW     = 16,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 24'hF00000,
    parameter logic [ADDR_W-1:0] RAM_BASE  = 24'h000000,
    parameter logic [ADDR_W-1:0] IO_BASE   = 24'hE00000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hE0FFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_i,
    input  logic [1:0]        kind_i,
    input  logic              wr_i,
    input  logic              as_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [2:0]        fc_o,
    output logic              rom_cs_o,
    output logic              ram_cs_o,
    output logic              io_cs_o,
    output logic              prot_fault_o
);
    fcd_state_t st_q, st_d;

    logic [2:0] fc_new;
    logic       sel_rom, sel_ram, sel_io;
    logic       start;
    logic       ctrl_wr;

    fcd_fc_encode u_enc (
        .sup_i (sup_i),
        .kind_i(kind_i),
        .fc_o  (fc_new)
    );

    fcd_region_decode #(
        .ADDR_W  (ADDR_W),
        .ROM_AW  (ROM_AW),
        .RAM_AW  (RAM_AW),
        .IO_AW   (IO_AW),
        .ROM_BASE(ROM_BASE),
        .RAM_BASE(RAM_BASE),
        .IO_BASE (IO_BASE)
    ) u_dec (
        .addr_i   (addr_i),
        .fc_i     (fc_new),
        .overlay_i(st_q.overlay),
        .sel_rom_o(sel_rom),
        .sel_ram_o(sel_ram),
        .sel_io_o (sel_io)
    );

    always_comb begin
        st_d       = st_q;
        start      = as_i && !st_q.as_prev;
        ctrl_wr    = sup_i && wr_i && (acc_kind_e'(kind_i) == ACC_DATA)
                     && (addr_i == CTRL_ADDR);
        st_d.as_prev = as_i;
        st_d.fault   = 1'b0;
        if (!as_i) begin
            st_d.rom_cs = 1'b0;
            st_d.ram_cs = 1'b0;
            st_d.io_cs  = 1'b0;
        end
        if (start) begin
            st_d.fc     = fc_new;
            st_d.rom_cs = sel_rom;
            st_d.ram_cs = sel_ram;
            st_d.io_cs  = sel_io && fc_new[2];
            st_d.fault  = sel_io && !fc_new[2];
            if (ctrl_wr) begin
                st_d.overlay = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fc: FC_RESET, rom_cs: 1'b0, ram_cs: 1'b0, io_cs: 1'b0,
                      fault: 1'b0, overlay: 1'b1, as_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fc_o         = st_q.fc;
    assign rom_cs_o     = st_q.rom_cs;
    assign ram_cs_o     = st_q.ram_cs;
    assign io_cs_o      = st_q.io_cs;
    assign prot_fault_o = st_q.fault;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       as_i,
    input logic [2:0] fc_o,
    input logic       rom_cs_o,
    input logic       ram_cs_o,
    input logic       io_cs_o,
    input logic       prot_fault_o
);
    p_cpu_space_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_o == 3'b111) |-> !(rom_cs_o || ram_cs_o || io_cs_o || prot_fault_o));

    p_fc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(as_i && !$past(as_i)) |=> $stable(fc_o));

    p_cs_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !as_i |=> !(rom_cs_o || ram_cs_o || io_cs_o));

    p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault_o |=> !prot_fault_o);

    p_fault_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault_o |-> (!fc_o[2] && !io_cs_o));

    p_one_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs_o, ram_cs_o, io_cs_o}));

    p_code_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_o != 3'b000) && (fc_o != 3'b011) && (fc_o != 3'b100));
endmodule

bind fc_space_decoder fcd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .as_i        (as_i),
    .fc_o        (fc_o),
    .rom_cs_o    (rom_cs_o),
    .ram_cs_o    (ram_cs_o),
    .io_cs_o     (io_cs_o),
    .prot_fault_o(prot_fault_o)
);

// File: tb/fc_space_decoder_tb.sv
module fc_space_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] CTRL = 24'hE0FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sup_i = 1'b0;
    logic [1:0]  kind_i = 2'd0;
    logic        wr_i = 1'b0;
    logic        as_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic [2:0]  fc_o;
    logic        rom_cs_o, ram_cs_o, io_cs_o, prot_fault_o;

    int checks = 0;
    int errors = 0;
    logic ovl = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    fc_space_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .sup_i(sup_i), .kind_i(kind_i), .wr_i(wr_i),
        .as_i(as_i), .addr_i(addr_i), .fc_o(fc_o), .rom_cs_o(rom_cs_o),
        .ram_cs_o(ram_cs_o), .io_cs_o(io_cs_o), .prot_fault_o(prot_fault_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_fc(input logic [1:0] k, input logic s);
        if (k == 2'd3) return 3'b111;
        if (k == 2'd2) return {s, 2'b01};
        return {s, 2'b10};
    endfunction

    // returns {fault, rom, ram, io}
    function automatic logic [3:0] exp_sel(input logic [1:0] k, input logic s,
                                           input logic [23:0] a, input logic ov);
        logic low, rom, ram, io;
        if (k == 2'd3) return 4'b0000;
        low = (a < 24'h010000);
        rom = (a >= 24'hF00000 && a < 24'hF10000) || (ov && low);
        ram = (a < 24'h100000) && !(ov && low);
        io  = (a >= 24'hE00000 && a < 24'hE10000);
        return {io && !s, rom, ram, io && s};
    endfunction

    function automatic string kind_req(input logic [1:0] k);
        case (k)
            2'd0: return "R2 fetch code";
            2'd1: return "R3 pc-relative code";
            2'd2: return "R4 data code";
            default: return "R5 cpu-space code";
        endcase
    endfunction

    task automatic access(input logic [1:0] k, input logic s, input logic w,
                          input logic [23:0] a);
        logic [2:0] efc;
        logic [3:0] es;
        efc = exp_fc(k, s);
        es  = exp_sel(k, s, a, ovl);
        @(negedge clk);
        kind_i = k; sup_i = s; wr_i = w; addr_i = a; as_i = 1'b1;
        @(negedge clk);
        chk(kind_req(k), {5'd0, fc_o}, {5'd0, efc});
        if (k != 2'd3) chk("R1 supervisor bit", {7'd0, fc_o[2]}, {7'd0, s});
        chk("R10 selects", {5'd0, rom_cs_o, ram_cs_o, io_cs_o}, {5'd0, es[2:0]});
        chk("R7 fault", {7'd0, prot_fault_o}, {7'd0, es[3]});
        sup_i = ~s; kind_i = k ^ 2'b01; addr_i = ~a; wr_i = ~w;
        @(negedge clk);
        chk("R6 code held", {5'd0, fc_o}, {5'd0, efc});
        chk("R6 selects held", {5'd0, rom_cs_o, ram_cs_o, io_cs_o}, {5'd0, es[2:0]});
        chk("R7 fault one cycle", {7'd0, prot_fault_o}, 8'd0);
        as_i = 1'b0;
        @(negedge clk);
        chk("R6 selects drop", {5'd0, rom_cs_o, ram_cs_o, io_cs_o}, 8'd0);
        chk("R6 code kept", {5'd0, fc_o}, {5'd0, efc});
        if (s && w && k == 2'd2 && a == CTRL) ovl = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R8 reset code", {5'd0, fc_o}, 8'h06);
        chk("R8 reset outputs", {4'd0, rom_cs_o, ram_cs_o, io_cs_o, prot_fault_o}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after reset", {5'd0, fc_o}, 8'h06);

        access(2'd0, 1'b1, 1'b0, 24'h000000);   // R8 overlay: ROM at zero
        access(2'd1, 1'b0, 1'b0, 24'h000100);   // R3 user PC-relative
        access(2'd2, 1'b0, 1'b0, 24'h080000);   // R4 RAM above the window
        access(2'd3, 1'b1, 1'b0, 24'h000000);   // R5 acknowledge
        access(2'd2, 1'b0, 1'b1, 24'hE00010);   // R7 user I/O refused
        access(2'd2, 1'b1, 1'b0, 24'hE00010);   // R7 supervisor I/O
        access(2'd2, 1'b0, 1'b1, CTRL);         // R9 user write: no clear
        access(2'd2, 1'b1, 1'b0, 24'h000004);   // R9 still ROM
        access(2'd2, 1'b1, 1'b1, CTRL);         // R9 supervisor clear
        access(2'd2, 1'b0, 1'b0, 24'h000004);   // R9 now RAM
        access(2'd0, 1'b1, 1'b0, 24'hF00200);   // R10 ROM region
        access(2'd2, 1'b1, 1'b1, 24'h800000);   // R10 unmapped

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ovl = 1'b1;

        for (int i = 0; i < 400; i++) begin
            logic [23:0] a;
            logic [2:0]  b;
            b = 3'($urandom_range(0, 5));
            case (b)
                3'd0: a = 24'($urandom_range(0, 24'h00FFFF));
                3'd1: a = 24'($urandom_range(24'h010000, 24'h0FFFFF));
                3'd2: a = 24'($urandom_range(24'hF00000, 24'hF0FFFF));
                3'd3: a = 24'($urandom_range(24'hE00000, 24'hE0FFFF));
                3'd4: a = 24'($urandom_range(24'h100000, 24'hDFFFFF));
                default: a = CTRL;
            endcase
            access(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), a);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule